// File: doc/BRIEF.md
# Interleaved Sample Output Demultiplexer

This block receives one 8-bit conversion result on every input clock edge. It routes successive results alternately to two output ports, A and B, and forwards a data clock that downstream logic uses to capture them. Port A takes a new value on the edge that drives the data clock high. Port B takes a new value on the edge that drives it low. Every result passes through a fixed latency of 15 input clock cycles before it reaches its port.

A mode input selects one of two modes. In normal mode every result is forwarded, and the data clock runs at half the input clock rate. In test mode only one result in five is kept and the rest are dropped. The kept results still alternate between A and B, so the data clock runs at one tenth of the input rate with equal high and low times. A phase-force input pair overrides the port choice for the result taken on a given edge. This lets several of these blocks be aligned so that together they interleave one stream.

Top module: `ilv_demux`

## Requirements
- R1: While `rst_n` is low at a clock edge, and for the first 15 edges after its release, `dclk` is 0 and `a_data` and `b_data` are both 0.
- R2: A sample present on `smp_in` at clock edge e appears on its port after edge e+15.
- R3: `a_data` changes only on an edge that leaves `dclk` at 1. `b_data` changes only on an edge that leaves `dclk` at 0. A write to A drives `dclk` to 1 and a write to B drives it to 0.
- R4: With `test_mode` = 0 and `phase_en` = 0, the first sample after reset goes to port A and later samples alternate B, A, B and so on. Once the stream is flowing, `dclk` toggles on every edge.
- R5: With `test_mode` = 1, the sample on the first edge in test mode is kept, and so is every fifth sample after it. The decimation count is held at zero while `test_mode` is 0. Kept samples continue the A/B alternation, so in steady state `dclk` is high for 5 cycles and low for 5.
- R6: A sample that is discarded in test mode never appears on either port.
- R7: When `phase_en` = 1 on an edge whose sample is kept, the sample goes to A if `phase_a` = 1 and to B if `phase_a` = 0. The next unforced kept sample goes to the other port.
- R8: In test mode, `phase_en` and `phase_a` have no effect on edges whose sample is discarded. This holds for both the data and the later alternation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input sample clock; every edge acquires one sample |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | 0 = forward every sample, 1 = keep one in five (tie low for normal use) |
| phase_en | input | 1 | Forces the port choice for this edge's sample |
| phase_a | input | 1 | Forced port when `phase_en` = 1: 1 = A, 0 = B |
| smp_in | input | 8 | Conversion result for this edge |
| dclk | output | 1 | Forwarded data clock; rises with A writes and falls with B writes |
| a_data | output | 8 | Port A sample |
| b_data | output | 8 | Port B sample |

## Verification
The demultiplexing is exercised with four stimulus patterns.

- **Free-running normal stream:** separates a correct A-first alternation and a correct 15-cycle latency from designs that are off by one edge or start on B.
- **Stream that switches from normal to test mode partway through:** shows whether the decimation count restarts on entry and whether the port alternation carries across the switch.
- **Normal stream with forced edges:** includes two consecutive forced B samples and a forced A. This shows that a force both picks the port and reseeds the alternation.
- **Test-mode stream forced on kept and discarded edges:** shows that a force on a discarded edge leaves both the data and the later port order untouched.

// File: rtl/ilv_pkg.sv
// Shared types for the interleaved sample output demultiplexer.
package ilv_pkg;

    // Destination port of one sample.
    typedef enum logic {
        PORT_B = 1'b0,
        PORT_A = 1'b1
    } port_e;

    // Routing tag carried alongside each sample through the latency pipe.
    // keep = 0 marks an empty or discarded slot.
    typedef struct packed {
        logic  keep;
        port_e port;
    } route_t;

endpackage

// File: rtl/ilv_steer.sv
// Acquisition-side steering: decides, on every input clock edge, whether
// the sample taken on that edge is kept and which port it is bound for.
// Assumes test_mode, phase_en and phase_a are synchronous to clk.
module ilv_steer
    import ilv_pkg::*;
#(
    parameter int DEC_N = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   test_mode,
    input  logic   phase_en,
    input  logic   phase_a,
    output route_t route
);

    localparam int CW = (DEC_N > 1) ? $clog2(DEC_N) : 1;
    localparam logic [CW-1:0] DEC_LAST = CW'(DEC_N - 1);

    logic [CW-1:0] dec_cnt;
    port_e         next_port;

    // Tag for the current edge: kept at count zero, forced port if requested.
    always_comb begin
        route.keep = !test_mode || (dec_cnt == '0);
        route.port = phase_en ? (phase_a ? PORT_A : PORT_B) : next_port;
    end

    // Decimation counter; idles at zero outside test mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_mode) begin
            dec_cnt <= '0;
        end else if (dec_cnt == DEC_LAST) begin
            dec_cnt <= '0;
        end else begin
            dec_cnt <= dec_cnt + 1'b1;
        end
    end

    // Port toggle; advances only when a sample is actually kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_port <= PORT_A;
        end else if (route.keep) begin
            next_port <= (route.port == PORT_A) ? PORT_B : PORT_A;
        end
    end

endmodule

// File: rtl/ilv_lat_pipe.sv
// Fixed-latency delay line for samples and their routing tags.
// The data field is not reset. The keep bit is reset, so slots that were
// filled before reset never reach the outputs.
module ilv_lat_pipe
    import ilv_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  route_t       r_in,
    output logic [W-1:0] d_out,
    output route_t       r_out
);

    logic [W-1:0] dq [DEPTH];
    route_t       rq [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic [W-1:0] d_src;
        route_t       r_src;

        if (i == 0) begin : g_head
            assign d_src = d_in;
            assign r_src = r_in;
        end else begin : g_body
            assign d_src = dq[i-1];
            assign r_src = rq[i-1];
        end

        // Data register of this stage.
        always_ff @(posedge clk) begin
            dq[i] <= d_src;
        end

        // Tag register of this stage; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rq[i] <= '{keep: 1'b0, port: PORT_B};
            end else begin
                rq[i] <= r_src;
            end
        end
    end

    assign d_out = dq[DEPTH-1];
    assign r_out = rq[DEPTH-1];

endmodule

// File: rtl/ilv_port_out.sv
// Output stage: writes a delayed kept sample into port A or B and drives
// the forwarded data clock high on A writes and low on B writes.
module ilv_port_out
    import ilv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  route_t       r_in,
    output logic         dclk,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q
);

    // Port registers and data clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk <= 1'b0;
            a_q  <= '0;
            b_q  <= '0;
        end else if (r_in.keep) begin
            if (r_in.port == PORT_A) begin
                a_q  <= d_in;
                dclk <= 1'b1;
            end else begin
                b_q  <= d_in;
                dclk <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ilv_demux.sv
// Top level: acquires one sample per clock edge, tags it with a keep bit
// and a destination port, delays it by LATENCY edges, and writes it to
// port A or B together with the forwarded data clock.
// Assumes one clock domain and a synchronous active-low reset.
module ilv_demux
    import ilv_pkg::*;
#(
    parameter int SMP_W   = 8,
    parameter int LATENCY = 15,
    parameter int DEC_N   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             phase_en,
    input  logic             phase_a,
    input  logic [SMP_W-1:0] smp_in,
    output logic             dclk,
    output logic [SMP_W-1:0] a_data,
    output logic [SMP_W-1:0] b_data
);

    route_t             acq_route;
    route_t             dly_route;
    logic [SMP_W-1:0]   dly_data;

    ilv_steer #(.DEC_N(DEC_N)) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .phase_en  (phase_en),
        .phase_a   (phase_a),
        .route     (acq_route)
    );

    ilv_lat_pipe #(.W(SMP_W), .DEPTH(LATENCY)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (smp_in),
        .r_in  (acq_route),
        .d_out (dly_data),
        .r_out (dly_route)
    );

    ilv_port_out #(.W(SMP_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (dly_data),
        .r_in  (dly_route),
        .dclk  (dclk),
        .a_q   (a_data),
        .b_q   (b_data)
    );

endmodule

// File: rtl/ilv_demux_chk.sv
// Property checker for ilv_demux, attached through bind.
// Observes the ports only; cycle counters give the history windows.
module ilv_demux_chk #(
    parameter int SMP_W   = 8,
    parameter int LATENCY = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_mode,
    input logic             phase_en,
    input logic [SMP_W-1:0] a_data,
    input logic [SMP_W-1:0] b_data,
    input logic             dclk
);

    localparam int CW = $clog2(LATENCY + 3) + 1;
    localparam logic [CW-1:0] FILL_MAX = CW'(LATENCY + 1);
    localparam logic [CW-1:0] RUN_MAX  = CW'(LATENCY + 2);

    logic [CW-1:0] fill_cnt;
    logic [CW-1:0] norm_run;

    // Edges since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (fill_cnt != FILL_MAX) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Consecutive edges acquired in normal mode without a force, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || test_mode || phase_en) begin
            norm_run <= '0;
        end else if (norm_run != RUN_MAX) begin
            norm_run <= norm_run + 1'b1;
        end
    end

    p_quiet_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt <= CW'(LATENCY)) |-> (!dclk && a_data == '0 && b_data == '0));

    p_a_with_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a_data) |-> dclk);

    p_b_with_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(b_data) |-> !dclk);

    p_half_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_run == RUN_MAX) |-> (dclk != $past(dclk)));

endmodule

bind ilv_demux ilv_demux_chk #(.SMP_W(SMP_W), .LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .phase_en  (phase_en),
    .a_data    (a_data),
    .b_data    (b_data),
    .dclk      (dclk)
);

// File: tb/sim_ilv_demux.sv
// Directed bench for ilv_demux: one task per scenario, with the expected
// port of every sample derived from the requirements.
module sim_ilv_demux;

    localparam int N = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode = 1'b0;
    logic       phase_en = 1'b0;
    logic       phase_a = 1'b0;
    logic [7:0] smp_in = 8'h00;
    logic       dclk;
    logic [7:0] a_data;
    logic [7:0] b_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Plan per acquisition edge j: inputs and expected route (0 none, 1 A, 2 B).
    logic [7:0] s_arr  [N];
    logic       tm_arr [N];
    logic       pe_arr [N];
    logic       pa_arr [N];
    int         rt_arr [N];

    always #2 clk = ~clk;

    ilv_demux u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .phase_en  (phase_en),
        .phase_a   (phase_a),
        .smp_in    (smp_in),
        .dclk      (dclk),
        .a_data    (a_data),
        .b_data    (b_data)
    );

    task automatic chk(string req, int k, logic [7:0] ea, logic [7:0] eb, logic ed);
        checks++;
        if (a_data !== ea || b_data !== eb || dclk !== ed) begin
            failures++;
            $display("FAIL %s edge %0d: a=%h b=%h dclk=%b expected a=%h b=%h dclk=%b",
                     req, k, a_data, b_data, dclk, ea, eb, ed);
        end
    endtask

    task automatic clear_plan(int seed);
        for (int j = 0; j < N; j++) begin
            s_arr[j]  = 8'((j * 53 + seed) & 255);
            tm_arr[j] = 1'b0;
            pe_arr[j] = 1'b0;
            pa_arr[j] = 1'b0;
            rt_arr[j] = 0;
        end
    endtask

    task automatic apply(int j);
        smp_in    = s_arr[j];
        test_mode = tm_arr[j];
        phase_en  = pe_arr[j];
        phase_a   = pa_arr[j];
    endtask

    // Reset, then stream edges 1..n, checking the ports after every edge.
    task automatic run(string req, int n);
        @(negedge clk);
        rst_n = 1'b0; test_mode = 1'b0; phase_en = 1'b0; phase_a = 1'b0; smp_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in reset", 0, 8'h00, 8'h00, 1'b0);
        rst_n = 1'b1;
        apply(1);
        for (int k = 1; k <= n; k++) begin
            logic [7:0] ea;
            logic [7:0] eb;
            logic       ed;
            @(posedge clk);
            @(negedge clk);
            ea = 8'h00; eb = 8'h00; ed = 1'b0;
            // R2: the sample of edge j is on its port after edge j+15.
            for (int j = 1; j <= k - 15; j++) begin
                if (rt_arr[j] == 1) begin ea = s_arr[j]; ed = 1'b1; end
                if (rt_arr[j] == 2) begin eb = s_arr[j]; ed = 1'b0; end
            end
            chk((k <= 15) ? "R1 fill" : req, k, ea, eb, ed);
            if (k + 1 < N) apply(k + 1);
        end
    endtask

    // R4 R2 R3: plain normal stream, A first then alternating.
    task automatic t_normal();
        clear_plan(0);
        for (int j = 1; j < N; j++) rt_arr[j] = (j % 2 == 1) ? 1 : 2;
        run("R2 R3 R4 normal", 40);
    endtask

    // R5 R6: three normal edges, then test mode from edge 4.
    task automatic t_test();
        clear_plan(17);
        rt_arr[1] = 1; rt_arr[2] = 2; rt_arr[3] = 1;
        for (int j = 4; j < N; j++) begin
            tm_arr[j] = 1'b1;
            if ((j - 4) % 5 == 0) rt_arr[j] = (((j - 4) / 5) % 2 == 0) ? 2 : 1;
        end
        run("R5 R6 test", 50);
    endtask

    // R7: forces in normal mode, including two consecutive forced B samples.
    task automatic t_phase();
        int nxt;
        clear_plan(101);
        pe_arr[5] = 1'b1;  pa_arr[5] = 1'b0;
        pe_arr[8] = 1'b1;  pa_arr[8] = 1'b0;
        pe_arr[12] = 1'b1; pa_arr[12] = 1'b0;
        pe_arr[13] = 1'b1; pa_arr[13] = 1'b0;
        pe_arr[20] = 1'b1; pa_arr[20] = 1'b1;
        nxt = 1;
        for (int j = 1; j < N; j++) begin
            rt_arr[j] = pe_arr[j] ? (pa_arr[j] ? 1 : 2) : nxt;
            nxt = (rt_arr[j] == 1) ? 2 : 1;
        end
        run("R7 phase normal", 45);
    endtask

    // R8 R7 R5: test mode with a force on a kept edge and one on a discarded edge.
    task automatic t_phase_test();
        int nxt;
        clear_plan(200);
        for (int j = 1; j < N; j++) tm_arr[j] = 1'b1;
        pe_arr[6] = 1'b1;  pa_arr[6] = 1'b1;
        pe_arr[8] = 1'b1;  pa_arr[8] = 1'b0;
        pe_arr[21] = 1'b1; pa_arr[21] = 1'b1;
        nxt = 1;
        for (int j = 1; j < N; j++) begin
            if ((j - 1) % 5 == 0) begin
                rt_arr[j] = pe_arr[j] ? (pa_arr[j] ? 1 : 2) : nxt;
                nxt = (rt_arr[j] == 1) ? 2 : 1;
            end
        end
        run("R8 R7 R5 phase test", 50);
    endtask

    initial begin
        t_normal();
        t_test();
        t_phase();
        t_phase_test();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule